// File: doc/BRIEF.md
# Double-Buffered Lighting Frame Store

The block sits between a producer of lighting-control frames (a line receiver or a host writing over a serial link) and a serial read port. It keeps two frame banks of 513 bytes each. Byte 0 of a frame is a mode byte and bytes 1 to 512 carry the 512 channel slots. The producer streams bytes into the back bank and then pulses a commit strobe, for example when chip-select goes high at the end of a host write. On commit the two banks trade roles, so the reader always sees one whole frame.

A reader frames its access with a level `rd_active` and steps through the front bank with `rd_next`, starting at byte 0. If a commit arrives while a read is open, the exchange is held and happens in the first cycle with `rd_active` low. A read therefore never mixes bytes from two frames. While the bytes are being written, each one is compared with the same position of the front frame. When the swap takes place, a one-cycle `new_frame` pulse is raised only if the frame that became visible differs from the one it replaced. The producer is expected to commit at most once every 20 ms. The block relies on this but does not enforce it.

Top module: `dmx_frame_store`

## Requirements
- R1: After reset `rd_data` is 0x00, `new_frame` is 0, and the committed frame is empty, so every byte read returns 0x00.
- R2: After `rd_active` rises, the k-th cycle with `rd_active` and `rd_next` both high (counting from 0) loads byte k of the committed frame into `rd_data`. The value appears one clock later. Byte 0 is the mode byte and bytes 1 to 512 are slots 1 to 512.
- R3: A read at an index at or beyond the committed frame length, including any index past 512, returns 0x00.
- R4: A commit taken with `rd_active` low makes the frame visible from the next cycle. This frame includes a byte presented with `in_valid` in the same cycle as `in_commit`.
- R5: A commit taken while `rd_active` is high leaves the open read on the old frame. The new frame becomes visible after the first cycle in which `rd_active` is low.
- R6: While a swap is pending, including the cycle in which it takes place, `in_valid` bytes and `in_commit` are discarded.
- R7: Bytes beyond the 513th of a frame are discarded. The committed frame keeps its first 513 bytes.
- R8: `new_frame` is high for exactly the one cycle after a swap, and only if the new frame differs from the previous one in length or in any byte.
- R9: Committing a frame identical in length and content to the visible one swaps the banks without raising `new_frame`.
- R10: `rd_next` has no effect while `rd_active` is low: `rd_data` holds its value, and the next read starts again at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present on in_data |
| in_data | input | 8 | Frame byte, written in stream order starting at the mode byte |
| in_commit | input | 1 | End of frame; frame is complete (one-cycle pulse) |
| rd_active | input | 1 | A read access is open (level) |
| rd_next | input | 1 | Fetch the next byte of the visible frame |
| rd_data | output | 8 | Last fetched byte |
| new_frame | output | 1 | One-cycle pulse: a changed frame became visible |

## Verification
The hardest situation to create is a commit that lands in the middle of an open read, followed by more producer traffic while the swap is still held. The stimulus opens a read and fetches a few bytes of the current frame. It then streams and commits a complete new frame while `rd_active` stays high, and sends a further short junk frame with its own commit. After that the read continues and must still return the old frame. Once `rd_active` drops, the bench expects the new-frame pulse in exactly that cycle and a fresh read of the new frame with no trace of the junk bytes. Length-only changes and oversized frames are also produced, to check the change detector and the 513-byte limit.

// File: rtl/dmx_fs_pkg.sv
package dmx_fs_pkg;

   localparam int unsigned DEF_SLOTS = 512;
   localparam int unsigned DEF_DW    = 8;

   // bits needed to hold a frame length of 0 .. slots+1
   function automatic int unsigned len_bits(input int unsigned slots);
      return $clog2(slots + 2);
   endfunction

endpackage

// File: rtl/dmx_fs_bank.sv
module dmx_fs_bank #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 513,
   localparam int unsigned IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [IW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/dmx_fs_fill.sv
module dmx_fs_fill #(
   parameter int unsigned DW        = 8,
   parameter int unsigned FRAME_LEN = 513,
   parameter int unsigned LW        = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          in_commit,
   input  logic          hold,
   input  logic [DW-1:0] front_byte,
   input  logic [LW-1:0] front_len,
   output logic          wr_en,
   output logic [LW-1:0] wr_ptr,
   output logic          commit_ok,
   output logic [LW-1:0] new_len,
   output logic          changed
);

   localparam logic [LW-1:0] LEN_MAX = LW'(FRAME_LEN);

   logic diff_q;
   logic room;
   logic byte_diff;

   assign room      = (wr_ptr < LEN_MAX);
   assign wr_en     = in_valid & ~hold & room;
   assign commit_ok = in_commit & ~hold;
   // positions past the front length are covered by the length compare
   assign byte_diff = (wr_ptr < front_len) && (front_byte != in_data);
   assign new_len   = wr_ptr + {{(LW-1){1'b0}}, wr_en};
   assign changed   = diff_q | (wr_en & byte_diff) | (new_len != front_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         diff_q <= 1'b0;
      end else if (commit_ok) begin
         wr_ptr <= '0;
         diff_q <= 1'b0;
      end else if (wr_en) begin
         wr_ptr <= wr_ptr + 1'b1;
         diff_q <= diff_q | byte_diff;
      end
   end

endmodule

// File: rtl/dmx_fs_read.sv
module dmx_fs_read #(
   parameter int unsigned DW        = 8,
   parameter int unsigned FRAME_LEN = 513,
   parameter int unsigned LW        = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_active,
   input  logic          rd_next,
   input  logic [DW-1:0] front_byte,
   input  logic [LW-1:0] front_len,
   output logic [LW-1:0] rd_ptr,
   output logic [DW-1:0] rd_data
);

   localparam logic [LW-1:0] LEN_MAX = LW'(FRAME_LEN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr  <= '0;
         rd_data <= '0;
      end else if (!rd_active) begin
         rd_ptr  <= '0;
      end else if (rd_next) begin
         rd_data <= (rd_ptr < front_len) ? front_byte : '0;
         if (rd_ptr != LEN_MAX) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dmx_frame_store.sv
module dmx_frame_store #(
   parameter int unsigned SLOTS = dmx_fs_pkg::DEF_SLOTS,
   parameter int unsigned DW    = dmx_fs_pkg::DEF_DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          in_commit,
   input  logic          rd_active,
   input  logic          rd_next,
   output logic [DW-1:0] rd_data,
   output logic          new_frame
);

   localparam int unsigned FRAME_LEN = SLOTS + 1;
   localparam int unsigned LW        = dmx_fs_pkg::len_bits(SLOTS);
   localparam int unsigned IW        = $clog2(FRAME_LEN);

   if (SLOTS < 1 || SLOTS > 512) begin : g_bad_slots
      initial $fatal(1, "dmx_frame_store: SLOTS must be 1..512");
   end
   if (DW < 1) begin : g_bad_dw
      initial $fatal(1, "dmx_frame_store: DW must be at least 1");
   end

   logic          front_sel;
   logic [LW-1:0] front_len;
   logic          pend;
   logic [LW-1:0] pend_len;
   logic          pend_chg;
   logic          irq_q;

   logic          wr_en;
   logic [LW-1:0] wr_ptr;
   logic          commit_ok;
   logic [LW-1:0] new_len;
   logic          changed;
   logic [LW-1:0] rd_ptr;

   logic [DW-1:0] port_a [2];
   logic [DW-1:0] port_b [2];
   logic [DW-1:0] front_wr_byte;
   logic [DW-1:0] front_rd_byte;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      dmx_fs_bank #(
         .DW    (DW),
         .DEPTH (FRAME_LEN)
      ) u_bank (
         .clk     (clk),
         .we      (wr_en & (front_sel != 1'(b))),
         .waddr   (wr_ptr[IW-1:0]),
         .wdata   (in_data),
         .raddr_a (wr_ptr[IW-1:0]),
         .rdata_a (port_a[b]),
         .raddr_b (rd_ptr[IW-1:0]),
         .rdata_b (port_b[b])
      );
   end

   assign front_wr_byte = port_a[front_sel];
   assign front_rd_byte = port_b[front_sel];

   dmx_fs_fill #(
      .DW        (DW),
      .FRAME_LEN (FRAME_LEN),
      .LW        (LW)
   ) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_commit  (in_commit),
      .hold       (pend),
      .front_byte (front_wr_byte),
      .front_len  (front_len),
      .wr_en      (wr_en),
      .wr_ptr     (wr_ptr),
      .commit_ok  (commit_ok),
      .new_len    (new_len),
      .changed    (changed)
   );

   dmx_fs_read #(
      .DW        (DW),
      .FRAME_LEN (FRAME_LEN),
      .LW        (LW)
   ) u_read (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_active  (rd_active),
      .rd_next    (rd_next),
      .front_byte (front_rd_byte),
      .front_len  (front_len),
      .rd_ptr     (rd_ptr),
      .rd_data    (rd_data)
   );

   // bank role control: swap at once when idle, else hold until the read ends
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         front_sel <= 1'b0;
         front_len <= '0;
         pend      <= 1'b0;
         pend_len  <= '0;
         pend_chg  <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (pend) begin
            if (!rd_active) begin
               front_sel <= ~front_sel;
               front_len <= pend_len;
               irq_q     <= pend_chg;
               pend      <= 1'b0;
            end
         end else if (commit_ok) begin
            if (rd_active) begin
               pend     <= 1'b1;
               pend_len <= new_len;
               pend_chg <= changed;
            end else begin
               front_sel <= ~front_sel;
               front_len <= new_len;
               irq_q     <= changed;
            end
         end
      end
   end

   assign new_frame = irq_q;

endmodule

// File: rtl/dmx_fs_checker.sv
module dmx_fs_checker #(
   parameter int unsigned DW        = 8,
   parameter int unsigned FRAME_LEN = 513,
   parameter int unsigned LW        = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_active,
   input logic          rd_next,
   input logic [DW-1:0] rd_data,
   input logic          new_frame,
   input logic          front_sel,
   input logic          pend,
   input logic [LW-1:0] rd_ptr,
   input logic [LW-1:0] wr_ptr
);

   a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_active && rd_next) |=> $stable(rd_data));

   a_r10_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_active |=> (rd_ptr == '0));

   a_r5_no_swap_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_active |=> $stable(front_sel));

   a_r5_pending_released: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !rd_active) |=> !pend);

   a_r8_pulse_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
      new_frame |-> (front_sel != $past(front_sel)));

   a_r3_zero_past_end: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_active && rd_next && rd_ptr >= LW'(FRAME_LEN)) |=> (rd_data == '0));

   a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr <= LW'(FRAME_LEN));

endmodule

bind dmx_frame_store dmx_fs_checker #(
   .DW        (DW),
   .FRAME_LEN (FRAME_LEN),
   .LW        (LW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_active (rd_active),
   .rd_next   (rd_next),
   .rd_data   (rd_data),
   .new_frame (new_frame),
   .front_sel (front_sel),
   .pend      (pend),
   .rd_ptr    (rd_ptr),
   .wr_ptr    (wr_ptr)
);

// File: tb/tb_dmx_frame_store.sv
`timescale 1ns/1ps
module tb_dmx_frame_store;

   localparam int FL = 513;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_commit = 1'b0;
   logic       rd_active = 1'b0;
   logic       rd_next = 1'b0;
   logic [7:0] rd_data;
   logic       new_frame;

   int  n_tests = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   int  tx_q[$];
   int  exp_f[$];
   int  rd_pos = 0;

   // behavioural reference state
   int  m_front[$];
   int  m_back[$];
   int  m_pend[$];
   bit  m_pending = 1'b0;
   bit  m_pchg = 1'b0;
   int  m_idx = 0;
   int  m_rd = 0;
   bit  m_irq = 1'b0;

   always #5 clk = ~clk;

   dmx_frame_store dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_commit (in_commit),
      .rd_active (rd_active),
      .rd_next   (rd_next),
      .rd_data   (rd_data),
      .new_frame (new_frame)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_front.delete(); m_back.delete(); m_pend.delete();
         m_pending = 1'b0; m_pchg = 1'b0; m_idx = 0; m_rd = 0; m_irq = 1'b0;
      end else begin
         bit chg;
         m_irq = 1'b0;
         if (rd_active && rd_next) begin
            m_rd = (m_idx < m_front.size()) ? m_front[m_idx] : 0;
            m_idx++;
         end else if (!rd_active) begin
            m_idx = 0;
         end
         if (m_pending) begin
            if (!rd_active) begin
               m_front = m_pend;
               m_irq = m_pchg;
               m_pending = 1'b0;
            end
         end else begin
            if (in_valid && m_back.size() < FL) m_back.push_back(int'(in_data));
            if (in_commit) begin
               chg = (m_back.size() != m_front.size());
               if (!chg) begin
                  for (int i = 0; i < m_back.size(); i++)
                     if (m_back[i] != m_front[i]) chg = 1'b1;
               end
               if (rd_active) begin
                  m_pending = 1'b1; m_pend = m_back; m_pchg = chg;
               end else begin
                  m_front = m_back; m_irq = chg;
               end
               m_back.delete();
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(rd_data == 8'(m_rd), "R2 per-cycle rd_data", int'(rd_data), m_rd);
         check(new_frame == m_irq, "R8 per-cycle new_frame", int'(new_frame), int'(m_irq));
      end
   end

   task automatic send_q(input bit chk, input bit exp_irq, input string tag);
      if (tx_q.size() == 0) begin
         @(negedge clk); in_commit = 1'b1;
      end
      for (int i = 0; i < tx_q.size(); i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data = 8'(tx_q[i]);
         in_commit = (i == tx_q.size() - 1);
      end
      @(posedge clk); #1;
      if (chk) check(new_frame == exp_irq, tag, int'(new_frame), int'(exp_irq));
      @(negedge clk);
      in_valid = 1'b0; in_commit = 1'b0;
   endtask

   task automatic rd_check(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         int e;
         @(negedge clk);
         rd_active = 1'b1; rd_next = 1'b1;
         @(posedge clk); #1;
         e = (rd_pos < exp_f.size()) ? exp_f[rd_pos] : 0;
         check(int'(rd_data) == e, tag, int'(rd_data), e);
         rd_pos++;
      end
      @(negedge clk);
      rd_next = 1'b0;
   endtask

   task automatic rd_stop();
      @(negedge clk);
      rd_active = 1'b0; rd_next = 1'b0;
      rd_pos = 0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      int held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(rd_data == 8'h00, "R1 rd_data after reset", int'(rd_data), 0);
      check(new_frame == 1'b0, "R1 new_frame after reset", int'(new_frame), 0);
      exp_f.delete();
      rd_check(4, "R1 empty frame reads zero");
      rd_stop();

      // full frame, last byte with the commit
      tx_q.delete();
      for (int i = 0; i < FL; i++) tx_q.push_back((i * 7 + 3) & 255);
      send_q(1'b1, 1'b1, "R8 first frame pulses");
      exp_f = tx_q;
      rd_check(FL + 3, "R4 committed frame visible");
      rd_stop();

      // identical frame
      send_q(1'b1, 1'b0, "R9 identical frame no pulse");
      rd_check(FL, "R9 identical frame content");
      rd_stop();

      // short frame
      tx_q.delete();
      for (int i = 0; i < 20; i++) tx_q.push_back((i * 13 + 1) & 255);
      send_q(1'b1, 1'b1, "R8 short frame pulses");
      exp_f = tx_q;
      rd_check(25, "R3 past length reads zero");

      // commit during an open read
      rd_check(0, "R5");
      tx_q.delete();
      for (int i = 0; i < FL; i++) tx_q.push_back((i * 5 + 200) & 255);
      send_q(1'b1, 1'b0, "R5 no pulse while read open");
      rd_check(6, "R5 open read keeps old frame");
      held = 0;
      // junk traffic while the swap is pending
      tx_q.delete();
      for (int i = 0; i < 5; i++) tx_q.push_back(i + 1);
      send_q(1'b1, 1'b0, "R6 no pulse for discarded commit");
      rd_check(4, "R6 open read still old frame");
      repeat (3) @(negedge clk);
      rd_stop();
      @(posedge clk); #1;
      check(new_frame == 1'b1, "R5 pulse when read ends", int'(new_frame), 1);
      exp_f.delete();
      for (int i = 0; i < FL; i++) exp_f.push_back((i * 5 + 200) & 255);
      rd_check(FL + 1, "R6 frame free of discarded bytes");
      rd_stop();

      // oversized frame
      tx_q.delete();
      for (int i = 0; i < 600; i++) tx_q.push_back((i * 3) & 255);
      send_q(1'b1, 1'b1, "R8 oversized frame pulses");
      exp_f.delete();
      for (int i = 0; i < FL; i++) exp_f.push_back(tx_q[i]);
      rd_check(FL + 2, "R7 only first 513 bytes kept");
      rd_stop();
      send_q(1'b1, 1'b0, "R9 oversized resend no pulse");

      // length-only change
      tx_q.delete();
      for (int i = 0; i < 100; i++) tx_q.push_back((i * 3) & 255);
      send_q(1'b1, 1'b1, "R8 length-only change pulses");
      exp_f = tx_q;
      rd_check(101, "R8 shortened frame content");
      rd_stop();

      // rd_next ignored while idle
      rd_check(3, "R10 setup read");
      rd_stop();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); rd_next = 1'b1;
      end
      @(negedge clk); rd_next = 1'b0;
      check(int'(rd_data) == exp_f[2], "R10 rd_data held", int'(rd_data), exp_f[2]);
      rd_check(2, "R10 read restarts at byte 0");
      rd_stop();

      // empty commit after a nonempty frame
      tx_q.delete();
      send_q(1'b1, 1'b1, "R8 empty frame pulses");
      exp_f.delete();
      rd_check(3, "R3 empty frame reads zero");
      rd_stop();

      repeat (4) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule